// File: doc/BRIEF.md
# Single-Precision Rounding Stage

This block takes an already normalized single-precision significand, with its hidden leading one, together with the biased exponent and sign. It also takes the two guard bits left over from an earlier arithmetic step: a round bit and a sticky bit. From these it produces the final packed 32-bit word. A 2-bit select chooses one of four rounding directions. From the select, the sign, the guard bits and the least significant fraction bit, the block decides whether to keep the truncated significand or to add one unit in the last place.

When adding one makes the significand carry out, the block shifts the result back to the form 1.000…0 and raises the exponent by one. If that raised exponent reaches the all-ones code, the output becomes a correctly signed infinity and an overflow flag is raised. An inexact flag reports that any guard information was discarded.

The stage sits after the normalizer of an adder or multiplier datapath. It has one register stage, so every accepted input produces a result exactly one clock later.

Top module: `fp_round_unit`

## Requirements
- R1: While reset is active and on the first cycle after it, `out_valid`, `out_word`, `out_inexact` and `out_overflow` are all zero.
- R2: A result appears with `out_valid` high exactly one cycle after `in_valid` is high. A cycle with `in_valid` low gives `out_valid` low one cycle later, and the output word and flags keep their previous values.
- R3: If adding one carries out of the significand and the exponent becomes 255, the output is infinity with the input sign (exponent field 255, fraction 0) and `out_overflow` is 1. Otherwise `out_overflow` is 0.
- R4: Mode code 00 selects nearest-even. With round/sticky 00 or 01 the fraction is truncated; with 11 it is incremented by one.
- R5: In mode 00 with round = 1 and sticky = 0 (a tie), the fraction is incremented when its bit 0 is 1 and truncated when it is 0.
- R6: Mode code 01 selects toward zero and always truncates, whatever the sign and guard bits.
- R7: Mode code 10 selects toward plus infinity. It increments only when the sign is 0 and round or sticky is 1; otherwise it truncates.
- R8: Mode code 11 selects toward minus infinity. It increments only when the sign is 1 and round or sticky is 1; otherwise it truncates.
- R9: When adding one to an all-ones significand carries out, the output fraction is zero and the output exponent is the input exponent plus one.
- R10: `out_inexact` equals round OR sticky of the accepted input.
- R11: The output is laid out as sign in bit 31, exponent in bits 30:23 and fraction in bits 22:0. The sign always equals the input sign. The exponent equals the input exponent whenever no carry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operand is present this cycle |
| in_sign | input | 1 | Sign of the value to round |
| in_exp | input | 8 | Biased exponent, 1 to 254 |
| in_sig | input | 24 | Normalized significand including the hidden bit |
| in_rbit | input | 1 | First bit below the last kept fraction bit |
| in_sbit | input | 1 | OR of all bits below the round bit |
| in_mode | input | 2 | Rounding direction select (see R4 to R8) |
| out_valid | output | 1 | Result word is valid |
| out_word | output | 32 | Packed rounded result |
| out_inexact | output | 1 | Guard information was discarded |
| out_overflow | output | 1 | Rounding pushed the exponent to infinity |

## Verification
An error in the increment decision shows up as a one-unit fraction error in the word one cycle after the operand. It can show up only for inputs whose guard bits and sign select the faulty branch, so every mode is driven with both signs and with each guard pattern. A wrong carry path appears only for an all-ones significand: the fraction is not cleared or the exponent does not step. Such faults are found by driving all-ones operands at an ordinary exponent and at 254, where the expected output is infinity. Stale register contents show up as a valid pulse, or a changed word, on a cycle with no accepted input.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST_EVEN = 2'b00,
        RM_TO_ZERO      = 2'b01,
        RM_TO_POS       = 2'b10,
        RM_TO_NEG       = 2'b11
    } round_mode_e;

endpackage

// File: rtl/fp_round_decide.sv
// Chooses between truncation and a one-ulp increment.
module fp_round_decide
    import fp_round_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       sign,
    input  logic       lsb,
    input  logic       rbit,
    input  logic       sbit,
    output logic       inc,
    output logic       inexact
);
    logic lost;
    assign lost    = rbit | sbit;
    assign inexact = lost;

    always_comb begin
        unique case (round_mode_e'(mode))
            RM_NEAREST_EVEN: inc = rbit & (sbit | lsb);
            RM_TO_ZERO:      inc = 1'b0;
            RM_TO_POS:       inc = lost & ~sign;
            RM_TO_NEG:       inc = lost & sign;
            default:         inc = 1'b0;
        endcase
    end
endmodule

// File: rtl/fp_round_incr.sv
// Adds the rounding increment and renormalizes on carry-out.
module fp_round_incr #(
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W:0]   sig,
    input  logic              inc,
    output logic [FRAC_W-1:0] frac,
    output logic              carry
);
    localparam int SIG_W = FRAC_W + 1;

    logic [SIG_W:0] sum;
    assign sum   = {1'b0, sig} + {{SIG_W{1'b0}}, inc};
    assign carry = sum[SIG_W];
    // On carry the value is 10.000..0; shift right by one.
    assign frac  = carry ? sum[SIG_W-1:1] : sum[FRAC_W-1:0];
endmodule

// File: rtl/fp_round_pack.sv
// Builds the output word and maps exponent saturation to infinity.
module fp_round_pack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [FRAC_W-1:0] frac,
    input  logic              carry,
    output logic [EXP_W+FRAC_W:0] word,
    output logic              ovf
);
    localparam int          EXP_MAX_I = (1 << EXP_W) - 1;
    localparam logic [EXP_W:0] EXP_MAX = EXP_MAX_I[EXP_W:0];

    logic [EXP_W:0] exp_sum;
    assign exp_sum = {1'b0, exp_in} + {{EXP_W{1'b0}}, carry};
    assign ovf     = carry && (exp_sum >= EXP_MAX);

    always_comb begin
        if (ovf) begin
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            word = {sign, exp_sum[EXP_W-1:0], frac};
        end
    end
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sign,
    input  logic [EXP_W-1:0]       in_exp,
    input  logic [FRAC_W:0]        in_sig,
    input  logic                   in_rbit,
    input  logic                   in_sbit,
    input  logic [1:0]             in_mode,
    output logic                   out_valid,
    output logic [EXP_W+FRAC_W:0]  out_word,
    output logic                   out_inexact,
    output logic                   out_overflow
);
    localparam int WORD_W = EXP_W + FRAC_W + 1;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        logic              inexact;
        logic              overflow;
    } state_t;

    state_t st_d, st_q;

    logic              inc_w, inexact_w, carry_w, ovf_w;
    logic [FRAC_W-1:0] frac_w;
    logic [WORD_W-1:0] word_w;

    fp_round_decide u_decide (
        .mode    (in_mode),
        .sign    (in_sign),
        .lsb     (in_sig[0]),
        .rbit    (in_rbit),
        .sbit    (in_sbit),
        .inc     (inc_w),
        .inexact (inexact_w)
    );

    fp_round_incr #(.FRAC_W(FRAC_W)) u_incr (
        .sig   (in_sig),
        .inc   (inc_w),
        .frac  (frac_w),
        .carry (carry_w)
    );

    fp_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
        .sign   (in_sign),
        .exp_in (in_exp),
        .frac   (frac_w),
        .carry  (carry_w),
        .word   (word_w),
        .ovf    (ovf_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.word     = word_w;
            st_d.inexact  = inexact_w;
            st_d.overflow = ovf_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.valid;
    assign out_word     = st_q.word;
    assign out_inexact  = st_q.inexact;
    assign out_overflow = st_q.overflow;
endmodule

// File: rtl/fp_round_unit_chk.sv
module fp_round_unit_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_sign,
    input logic [EXP_W-1:0]      in_exp,
    input logic [FRAC_W-1:0]     in_frac,
    input logic                  in_rbit,
    input logic                  in_sbit,
    input logic [1:0]            in_mode,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] out_word,
    input logic                  out_inexact,
    input logic                  out_overflow
);
    localparam int TOP = EXP_W + FRAC_W;

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_overflow)));

    assert_ovf_is_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow) |->
            (out_word[TOP-1:FRAC_W] == {EXP_W{1'b1}} && out_word[FRAC_W-1:0] == '0));

    assert_exact_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_rbit && !in_sbit) |=>
            (out_word == {$past(in_sign), $past(in_exp), $past(in_frac)}));

    assert_to_zero_trunc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b01) |=>
            (out_word[FRAC_W-1:0] == $past(in_frac) && out_word[TOP-1:FRAC_W] == $past(in_exp)
             && !out_overflow));

    assert_inexact_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_inexact == ($past(in_rbit) | $past(in_sbit))));

    assert_sign_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_word[TOP] == $past(in_sign)));
endmodule

bind fp_round_unit fp_round_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_sign      (in_sign),
    .in_exp       (in_exp),
    .in_frac      (in_sig[FRAC_W-1:0]),
    .in_rbit      (in_rbit),
    .in_sbit      (in_sbit),
    .in_mode      (in_mode),
    .out_valid    (out_valid),
    .out_word     (out_word),
    .out_inexact  (out_inexact),
    .out_overflow (out_overflow)
);

// File: tb/fp_round_unit_tb_top.sv
module fp_round_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [7:0]  in_exp = '0;
    logic [23:0] in_sig = '0;
    logic        in_rbit = 1'b0;
    logic        in_sbit = 1'b0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_inexact;
    logic        out_overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fp_round_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sign      (in_sign),
        .in_exp       (in_exp),
        .in_sig       (in_sig),
        .in_rbit      (in_rbit),
        .in_sbit      (in_sbit),
        .in_mode      (in_mode),
        .out_valid    (out_valid),
        .out_word     (out_word),
        .out_inexact  (out_inexact),
        .out_overflow (out_overflow)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Drive one operand at a falling edge; check at the next falling edge.
    task automatic round_one(input string tag, input logic s, input logic [7:0] e,
                             input logic [23:0] sig, input logic r, input logic st,
                             input logic [1:0] m, input logic [31:0] w_exp,
                             input logic ovf_exp);
        @(negedge clk);
        in_valid = 1'b1; in_sign = s; in_exp = e; in_sig = sig;
        in_rbit = r; in_sbit = st; in_mode = m;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " word"}, out_word, w_exp);
        check({tag, " valid R2"}, {31'd0, out_valid}, 32'd1);
        check({tag, " inexact R10"}, {31'd0, out_inexact}, {31'd0, r | st});
        check({tag, " overflow R3"}, {31'd0, out_overflow}, {31'd0, ovf_exp});
    endtask

    task automatic t_reset_r1();
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 word", out_word, 32'd0);
        check("R1 flags", {30'd0, out_inexact, out_overflow}, 32'd0);
    endtask

    task automatic t_nearest_r4();
        round_one("R4 rs00", 1'b0, 8'h80, 24'hC00000, 1'b0, 1'b0, 2'b00, 32'h40400000, 1'b0);
        round_one("R4 rs01", 1'b0, 8'h80, 24'hC00000, 1'b0, 1'b1, 2'b00, 32'h40400000, 1'b0);
        round_one("R4 rs11", 1'b0, 8'h80, 24'hC00000, 1'b1, 1'b1, 2'b00, 32'h40400001, 1'b0);
    endtask

    task automatic t_tie_r5();
        round_one("R5 tie even", 1'b0, 8'h80, 24'hC00000, 1'b1, 1'b0, 2'b00, 32'h40400000, 1'b0);
        round_one("R5 tie odd", 1'b1, 8'h80, 24'hC00001, 1'b1, 1'b0, 2'b00, 32'hC0400002, 1'b0);
    endtask

    task automatic t_zero_r6();
        round_one("R6 neg", 1'b1, 8'h80, 24'hC00001, 1'b1, 1'b1, 2'b01, 32'hC0400001, 1'b0);
        round_one("R6 allones", 1'b0, 8'hFE, 24'hFFFFFF, 1'b1, 1'b1, 2'b01, 32'h7F7FFFFF, 1'b0);
    endtask

    task automatic t_pos_r7();
        round_one("R7 pos", 1'b0, 8'h80, 24'hC00001, 1'b0, 1'b1, 2'b10, 32'h40400002, 1'b0);
        round_one("R7 neg", 1'b1, 8'h80, 24'hC00001, 1'b1, 1'b1, 2'b10, 32'hC0400001, 1'b0);
    endtask

    task automatic t_neg_r8();
        round_one("R8 neg", 1'b1, 8'h80, 24'hC00001, 1'b1, 1'b0, 2'b11, 32'hC0400002, 1'b0);
        round_one("R8 pos", 1'b0, 8'h80, 24'hC00001, 1'b1, 1'b1, 2'b11, 32'h40400001, 1'b0);
    endtask

    task automatic t_carry_r9();
        round_one("R9 rne", 1'b1, 8'h79, 24'hFFFFFF, 1'b1, 1'b0, 2'b00, 32'hBD000000, 1'b0);
        round_one("R9 down", 1'b1, 8'h79, 24'hFFFFFF, 1'b0, 1'b1, 2'b11, 32'hBD000000, 1'b0);
    endtask

    task automatic t_ovf_r3();
        round_one("R3 pos inf", 1'b0, 8'hFE, 24'hFFFFFF, 1'b0, 1'b1, 2'b10, 32'h7F800000, 1'b1);
        round_one("R3 neg inf", 1'b1, 8'hFE, 24'hFFFFFF, 1'b1, 1'b1, 2'b00, 32'hFF800000, 1'b1);
    endtask

    task automatic t_hold_r2();
        logic [31:0] prev;
        round_one("R2 load", 1'b0, 8'h81, 24'h800000, 1'b0, 1'b0, 2'b00, 32'h40800000, 1'b0);
        prev = out_word;
        in_sig = 24'hFFFFFF; in_rbit = 1'b1; in_exp = 8'hFE;
        @(negedge clk);
        check("R2 idle valid", {31'd0, out_valid}, 32'd0);
        check("R2 idle hold", out_word, prev);
        check("R2 idle flags", {30'd0, out_inexact, out_overflow}, 32'd0);
    endtask

    task automatic t_sign_r11();
        round_one("R11 sign", 1'b1, 8'h01, 24'h800000, 1'b0, 1'b0, 2'b10, 32'h80800000, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset_r1();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_nearest_r4();
        t_tie_r5();
        t_zero_r6();
        t_pos_r7();
        t_neg_r8();
        t_carry_r9();
        t_ovf_r3();
        t_hold_r2();
        t_sign_r11();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule